// File: doc/BRIEF.md
# Polled Character Output Port

This block is a character output device on a 16-bit load/store bus. It has two registers. The status register carries a ready flag and an interrupt enable. The data register takes a character from the processor. Software reads the status word until the ready flag is one, then stores a word to the data register. The low byte of that word goes to the display side as a one-cycle valid pulse.

After a store has been accepted, ready stays low until the display side raises its completion input. While ready is low, stores to the data register are dropped, so a slow display is never overrun. When software has set the enable bit, an interrupt request is raised whenever the port is ready. The processor can then use that request instead of polling.

Top module: `disp_port`

## Requirements
- R1: After reset, ready is 1, the interrupt enable is 0, `disp_valid` is 0, `irq` is 0 and the held character is 0x00.
- R2: A read at address 0xFE04 returns ready in bit 15, the interrupt enable in bit 14, and zero in bits [13:0].
- R3: A store to address 0xFE06 while ready is 1 raises `disp_valid` at the next clock edge, with `disp_char` equal to bits [7:0] of the stored word.
- R4: An accepted store clears ready at the same edge that raises `disp_valid`.
- R5: A store to 0xFE06 while ready is 0 produces no `disp_valid` pulse and leaves the held character unchanged.
- R6: `disp_done` while ready is 0 sets ready at the next edge. While ready is 1, `disp_done` has no effect.
- R7: A store to 0xFE04 loads bit 14 of the stored word into the interrupt enable. Bit 15 of that store does not change ready.
- R8: `irq` is 1 exactly when ready and the interrupt enable are both 1.
- R9: A read at 0xFE06 returns the last accepted character zero-extended. A read at any other address returns zero, and a store to any other address changes nothing.
- R10: `disp_valid` is high for exactly one cycle per accepted store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Bus address |
| bus_wr | input | 1 | Store strobe |
| bus_rd | input | 1 | Load strobe; gates the read data |
| bus_wdata | input | 16 | Store data |
| bus_rdata | output | 16 | Load data (combinational) |
| disp_valid | output | 1 | One-cycle pulse for a new character |
| disp_char | output | 8 | Character to display |
| disp_done | input | 1 | Display has finished the character |
| irq | output | 1 | Interrupt request |

## Verification
A wrong ready flag shows up on the next status read. It also shows one cycle after the next store, as a missing or extra `disp_valid` pulse. A corrupted enable or ready bit appears on `irq` in the same cycle. A wrong held character is visible on `disp_char` one cycle after an accepted store, and on the next data-register read. The random mix interleaves stores, loads and completions so that every such fault reaches a port within a few cycles.

// File: rtl/disp_pkg.sv
package disp_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              ready;
        logic              ien;
        logic              valid;
        logic [CHAR_W-1:0] chr;
    } disp_state_t;

    localparam disp_state_t DISP_RESET = '{ready: 1'b1, ien: 1'b0,
                                           valid: 1'b0, chr: '0};
endpackage

// File: rtl/disp_decode.sv
module disp_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] STAT_ADDR = 16'hFE04,
    parameter logic [15:0] DATA_ADDR = 16'hFE06
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_stat,
    output logic              wr_data,
    output logic              rd_stat,
    output logic              rd_data
);
    logic hit_stat, hit_data;

    always_comb begin
        hit_stat = (addr == ADDR_W'(STAT_ADDR));
        hit_data = (addr == ADDR_W'(DATA_ADDR));
        wr_stat  = wr && hit_stat;
        wr_data  = wr && hit_data;
        rd_stat  = rd && hit_stat;
        rd_data  = rd && hit_data;
    end
endmodule

// File: rtl/disp_ctrl.sv
module disp_ctrl
    import disp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic              wr_data,
    input  logic              ien_bit,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              done,
    output logic              ready,
    output logic              ien,
    output logic              valid,
    output logic [CHAR_W-1:0] chr,
    output logic              irq
);
    disp_state_t st_d, st_q;
    logic        accept_d;

    always_comb begin
        st_d     = st_q;
        accept_d = wr_data && st_q.ready;
        st_d.valid = accept_d;
        if (wr_stat) begin
            st_d.ien = ien_bit;
        end
        if (accept_d) begin
            st_d.chr   = wchar;
            st_d.ready = 1'b0;
        end else if (!st_q.ready && done) begin
            st_d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= DISP_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        ready = st_q.ready;
        ien   = st_q.ien;
        valid = st_q.valid;
        chr   = st_q.chr;
        irq   = st_q.ready && st_q.ien;
    end
endmodule

// File: rtl/disp_rdmux.sv
module disp_rdmux
    import disp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              rd_stat,
    input  logic              rd_data,
    input  logic              ready,
    input  logic              ien,
    input  logic [CHAR_W-1:0] chr,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD_W = DATA_W - CHAR_W;

    logic [DATA_W-1:0] stat_word, data_word;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb data_word = {{PAD_W{1'b0}}, chr};
        end else begin : g_nopad
            always_comb data_word = chr[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        stat_word             = '0;
        stat_word[DATA_W-1]   = ready;
        stat_word[DATA_W-2]   = ien;
        if (rd_stat)      rdata = stat_word;
        else if (rd_data) rdata = data_word;
        else              rdata = '0;
    end
endmodule

// File: rtl/disp_port.sv
module disp_port
    import disp_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 16,
    parameter logic [15:0] STAT_ADDR = 16'hFE04,
    parameter logic [15:0] DATA_ADDR = 16'hFE06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              disp_valid,
    output logic [CHAR_W-1:0] disp_char,
    input  logic              disp_done,
    output logic              irq
);
    logic wr_stat, wr_data, rd_stat, rd_data;
    logic ready_w, ien_w;
    logic unused_wbits;

    assign unused_wbits = ^{bus_wdata[DATA_W-1], bus_wdata[DATA_W-3:CHAR_W]};

    disp_decode #(
        .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wr_stat(wr_stat), .wr_data(wr_data),
        .rd_stat(rd_stat), .rd_data(rd_data)
    );

    disp_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_stat(wr_stat), .wr_data(wr_data),
        .ien_bit(bus_wdata[DATA_W-2]), .wchar(bus_wdata[CHAR_W-1:0]),
        .done(disp_done),
        .ready(ready_w), .ien(ien_w),
        .valid(disp_valid), .chr(disp_char), .irq(irq)
    );

    disp_rdmux #(.DATA_W(DATA_W)) u_rd (
        .rd_stat(rd_stat), .rd_data(rd_data),
        .ready(ready_w), .ien(ien_w), .chr(disp_char),
        .rdata(bus_rdata)
    );
endmodule

// File: rtl/disp_port_chk.sv
module disp_port_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] DATA_ADDR = 16'hFE06
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        wlo,
    input logic              disp_done,
    input logic              disp_valid,
    input logic [7:0]        disp_char,
    input logic              ready
);
    logic store_d;
    assign store_d = bus_wr && (bus_addr == ADDR_W'(DATA_ADDR));

    p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (store_d && ready) |=> (disp_valid && disp_char == $past(wlo)));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_d && ready) |=> !ready);

    p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (store_d && !ready) |=> (!disp_valid && $stable(disp_char)));

    p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && disp_done) |=> ready);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !disp_done) |=> !ready);

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |=> !disp_valid);
endmodule

bind disp_port disp_port_chk #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wlo(bus_wdata[7:0]), .disp_done(disp_done), .disp_valid(disp_valid),
    .disp_char(disp_char), .ready(ready_w)
);

// File: tb/sim_disp_port.sv
module sim_disp_port;
    localparam logic [15:0] A_STAT = 16'hFE04;
    localparam logic [15:0] A_DATA = 16'hFE06;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_wr, bus_rd, disp_done;
    logic        disp_valid, irq;
    logic [7:0]  disp_char;

    int checks = 0, errors = 0, cycles = 0;
    bit m_ready, m_ien, m_valid;
    logic [7:0] m_chr;
    int unsigned seed_dummy;

    always #10 clk = ~clk;

    disp_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .disp_valid(disp_valid), .disp_char(disp_char),
        .disp_done(disp_done), .irq(irq)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rdata(input logic [15:0] a);
        if (a == A_STAT) return {m_ready, m_ien, 14'b0};
        if (a == A_DATA) return {8'h00, m_chr};
        return 16'h0000;
    endfunction

    // One bus cycle: drive at negedge, check read data, clock, update model, check outputs
    task automatic cyc(input bit wr, input bit rd, input logic [15:0] a,
                       input logic [15:0] wd, input bit dn);
        logic [15:0] er;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd; disp_done = dn;
        #1;
        if (rd) begin
            er = exp_rdata(a);
            chk(bus_rdata === er, (a == A_STAT) ? "R2" : "R9", 32'(bus_rdata), 32'(er));
        end
        @(posedge clk);
        if (wr && a == A_STAT) m_ien = wd[14];
        if (wr && a == A_DATA && m_ready) begin
            m_chr = wd[7:0]; m_ready = 0; m_valid = 1;
        end else begin
            m_valid = 0;
            if (!m_ready && dn) m_ready = 1;
        end
        @(negedge clk);
        chk(disp_valid === m_valid, m_valid ? "R3" : "R5", 32'(disp_valid), 32'(m_valid));
        chk(disp_char === m_chr, m_valid ? "R3" : "R5", 32'(disp_char), 32'(m_chr));
        chk(irq === (m_ready && m_ien), "R8", 32'(irq), 32'(m_ready && m_ien));
        bus_wr = 0; bus_rd = 0; disp_done = 0;
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        seed_dummy = $urandom(32'd1234);
        rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; disp_done = 0;
        m_ready = 1; m_ien = 0; m_valid = 0; m_chr = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(disp_valid === 1'b0, "R1", 32'(disp_valid), 0);
        chk(irq === 1'b0, "R1", 32'(irq), 0);
        chk(disp_char === 8'h00, "R1", 32'(disp_char), 0);
        cyc(0, 1, A_STAT, 0, 0);                 // R1/R2: ready=1, ien=0
        // R3/R4: accepted store, then ready reads low
        cyc(1, 0, A_DATA, 16'hAB41, 0);
        cyc(0, 1, A_STAT, 0, 0);
        chk(disp_valid === 1'b0, "R10", 32'(disp_valid), 0);
        // R5: store while not ready is dropped
        cyc(1, 0, A_DATA, 16'h0055, 0);
        cyc(0, 1, A_DATA, 0, 0);                 // R9: still 0x41
        // R6: done sets ready; done while ready no effect
        cyc(0, 0, A_STAT, 0, 1);
        cyc(0, 1, A_STAT, 0, 1);
        // R7: enable via bit 14; bit 15 does not touch ready
        cyc(1, 0, A_STAT, 16'h4000, 0);
        cyc(1, 0, A_DATA, 16'h0033, 0);
        cyc(1, 0, A_STAT, 16'hC000, 0);
        cyc(0, 1, A_STAT, 0, 0);                 // R7: ready must stay 0
        cyc(0, 0, A_STAT, 0, 1);                 // R8: irq rises
        // R9: other addresses
        cyc(1, 0, 16'hFE02, 16'h00EE, 0);
        cyc(0, 1, 16'hFE02, 0, 0);
        cyc(0, 1, A_DATA, 0, 0);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            logic [15:0] a;
            r = $urandom_range(0, 9);
            a = (r < 4) ? A_DATA : (r < 8) ? A_STAT : 16'($urandom);
            cyc($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a,
                16'($urandom), $urandom_range(0, 3) == 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule